// File: doc/BRIEF.md
# Carrier divider and write modulator

This block takes the reader's oscillator clock, which may run at one of four rates, and divides it down to a fixed 125 kHz carrier. The carrier drives two coil driver outputs as a full bridge, so the two legs are always in antiphase. The block also exports a one-cycle tick per carrier period and a 6-bit slot index that sweeps each period in 64 steps. A phase measurement unit elsewhere uses that index.

To write to a transponder, a command decoder pulses `wr_enter` and the block enters write mode. There are two ways to gate the carrier off. With a zero pulse width, the serial data line switches the drivers directly: high turns them off and low turns them on. With a nonzero width N, a rising data edge starts a self-timed gap of exactly N carrier periods. A rising edge on the serial clock leaves write mode at once. The driver disable bit and the power-down bit override everything else. Power-down also freezes the divider, because the clock source is treated as stopped.

Top module: `carrier_write_mod`

## Requirements
- R1: The divide ratio follows `freq_sel`: 0 gives 32, 1 gives 96, 2 gives 64 and 3 gives 128 clock cycles per carrier period. `carrier_tick` is high for exactly one cycle in each period, in the period's last slot.
- R2: Outside any off condition, exactly one of `tx1`/`tx2` is high in every cycle. `tx1` is high for the first half of each period and `tx2` for the second half. Both legs are never high together.
- R3: In write mode with `pulse_n` = 0, `din` = 1 holds both legs low. `din` = 0 lets the carrier through. The drivers react one clock after `din` changes.
- R4: In write mode with `pulse_n` from 1 to 15, a rising edge on `din` holds both legs low for exactly `pulse_n` × ratio consecutive cycles, starting one clock after the edge. After the gap the carrier returns whatever level `din` is at.
- R5: A rising edge on `din` while a timed gap is running is ignored: it neither extends nor restarts the gap.
- R6: A rising edge on `sclk` ends write mode and cancels a running gap. The carrier is back on the legs one clock later.
- R7: While `tx_dis` = 1, both legs are low. The divider keeps running and the tick keeps coming.
- R8: While `pwr_down` = 1, both legs are low, `carrier_tick` stays 0 and `slot_idx` holds its value.
- R9: `slot_idx` equals floor(c × 64 / ratio), where c is the clock count since the period began, from 0 to ratio − 1. It reads 0 in the cycle after each tick.
- R10: Outside write mode, `din` has no effect on the legs.
- R11: The divider runs on through a write gap: exactly `pulse_n` ticks appear during a gap of `pulse_n` periods.
- R12: While `rst` is high, the legs, the tick and the slot index are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| freq_sel | input | 2 | Oscillator rate select (0: 4 MHz, 1: 12 MHz, 2: 8 MHz, 3: 16 MHz) |
| tx_dis | input | 1 | Driver disable, 1 holds both legs low |
| pwr_down | input | 1 | Power-down: legs low, divider frozen |
| wr_enter | input | 1 | One-cycle pulse that enters write mode |
| pulse_n | input | 4 | Write gap length in carrier periods, 0 for transparent gating |
| din | input | 1 | Serial data line, synchronous to clk |
| sclk | input | 1 | Serial clock, its rising edge ends write mode |
| tx1 | output | 1 | Coil driver leg, high in the first half-period |
| tx2 | output | 1 | Coil driver leg, complement of tx1 |
| carrier_tick | output | 1 | One-cycle pulse in the last slot of each period |
| slot_idx | output | 6 | Position within the carrier period, 0 to 63 |

## Verification
The bench measures each gap as a run of cycles with both legs low. It does this once with a second data rising edge injected mid-gap, and once at the 12 MHz ratio. A timer that restarted on the extra edge, or that counted carrier ticks instead of clocks, would give a run longer or shorter than N × ratio. Every clock of a full period is compared against floor(c × 64 / ratio) and against the half-period split, at all four rates. An off-by-one wrap or a wrong divisor at the 96 ratio would show up at once. Serial-clock exit is tried both from transparent mode with data held high and from the middle of a 15-period gap. A design that waited for the gap to finish, or that kept transparent gating, would leave the legs low.

// File: rtl/cwm_pkg.sv
package cwm_pkg;

    localparam int SLOT_W = 6;

    typedef enum logic [1:0] {
        CLK_4M  = 2'b00,
        CLK_12M = 2'b01,
        CLK_8M  = 2'b10,
        CLK_16M = 2'b11
    } osc_sel_e;

    // Divider state as seen by the output stage
    typedef struct packed {
        logic              hi;
        logic              wrap;
        logic [SLOT_W-1:0] slot;
    } car_t;

    // Multiple of the base ratio for each oscillator rate
    function automatic int unsigned div_mult(osc_sel_e s);
        case (s)
            CLK_4M:  return 1;
            CLK_12M: return 3;
            CLK_8M:  return 2;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/cwm_divider.sv
module cwm_divider
    import cwm_pkg::*;
#(
    parameter  int BASE_DIV = 32,
    localparam int CNT_W    = $clog2(4 * BASE_DIV),
    localparam int RAT_W    = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  osc_sel_e         sel,
    input  logic             freeze,
    output car_t             car,
    output logic [RAT_W-1:0] ratio
);

    localparam int SCL_W = CNT_W + SLOT_W;

    logic [CNT_W-1:0] cnt_q;
    logic [SCL_W-1:0] scaled;
    logic [SCL_W-1:0] quot;

    assign ratio    = RAT_W'(BASE_DIV * div_mult(sel));
    assign car.wrap = {1'b0, cnt_q} >= (ratio - RAT_W'(1));
    assign car.hi   = {1'b0, cnt_q} < (ratio >> 1);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (!freeze)
            cnt_q <= car.wrap ? '0 : cnt_q + CNT_W'(1);
    end

    // Constant divisor per branch keeps each path a fixed scaling
    assign scaled = {cnt_q, {SLOT_W{1'b0}}};
    always_comb begin
        case (sel)
            CLK_4M:  quot = SCL_W'(scaled / (BASE_DIV * 1));
            CLK_12M: quot = SCL_W'(scaled / (BASE_DIV * 3));
            CLK_8M:  quot = SCL_W'(scaled / (BASE_DIV * 2));
            default: quot = SCL_W'(scaled / (BASE_DIV * 4));
        endcase
    end
    assign car.slot = quot[SLOT_W-1:0];

endmodule

// File: rtl/cwm_gate.sv
module cwm_gate #(
    parameter  int N_W   = 4,
    parameter  int RAT_W = 8,
    localparam int GAP_W = N_W + RAT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_enter,
    input  logic             din,
    input  logic             sclk,
    input  logic [N_W-1:0]   pulse_n,
    input  logic [RAT_W-1:0] ratio,
    output logic             gate_off
);

    logic             din_q;
    logic             sclk_q;
    logic             wr_q;
    logic [GAP_W-1:0] gap_q;

    logic             din_rise;
    logic             sclk_rise;
    logic             wr_live;
    logic             timed;
    logic             gap_busy;
    logic             gap_start;
    logic [GAP_W-1:0] gap_len;

    assign din_rise  = din & ~din_q;
    assign sclk_rise = sclk & ~sclk_q;
    assign wr_live   = (wr_q | wr_enter) & ~sclk_rise;
    assign timed     = pulse_n != '0;
    assign gap_busy  = gap_q != '0;
    assign gap_start = wr_live & timed & din_rise & ~gap_busy;
    assign gap_len   = GAP_W'(GAP_W'(pulse_n) * GAP_W'(ratio) - GAP_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            din_q  <= 1'b0;
            sclk_q <= 1'b0;
            wr_q   <= 1'b0;
            gap_q  <= '0;
        end else begin
            din_q  <= din;
            sclk_q <= sclk;
            wr_q   <= wr_live;
            if (!wr_live)
                gap_q <= '0;
            else if (gap_start)
                gap_q <= gap_len;
            else if (gap_busy)
                gap_q <= gap_q - GAP_W'(1);
        end
    end

    assign gate_off = wr_live & (timed ? (gap_busy | gap_start) : din);

endmodule

// File: rtl/cwm_bridge.sv
module cwm_bridge
    import cwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  car_t              car,
    input  logic              tick_in,
    input  logic              drv_on,
    output logic              tx1,
    output logic              tx2,
    output logic              tick,
    output logic [SLOT_W-1:0] slot
);

    logic [1:0] leg_q;

    // Leg 0 follows the carrier, leg 1 its complement
    for (genvar g = 0; g < 2; g++) begin : g_leg
        always_ff @(posedge clk) begin
            if (rst)
                leg_q[g] <= 1'b0;
            else
                leg_q[g] <= drv_on & (car.hi ^ (g == 1));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tick <= 1'b0;
            slot <= '0;
        end else begin
            tick <= tick_in;
            slot <= car.slot;
        end
    end

    assign tx1 = leg_q[0];
    assign tx2 = leg_q[1];

endmodule

// File: rtl/carrier_write_mod.sv
module carrier_write_mod
    import cwm_pkg::*;
#(
    parameter int BASE_DIV = 32,
    parameter int N_W      = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        freq_sel,
    input  logic              tx_dis,
    input  logic              pwr_down,
    input  logic              wr_enter,
    input  logic [N_W-1:0]    pulse_n,
    input  logic              din,
    input  logic              sclk,
    output logic              tx1,
    output logic              tx2,
    output logic              carrier_tick,
    output logic [SLOT_W-1:0] slot_idx
);

    localparam int RAT_W = $clog2(4 * BASE_DIV) + 1;

    car_t             car;
    logic [RAT_W-1:0] ratio;
    logic             gate_off;
    logic             drv_on;
    logic             tick_c;

    cwm_divider #(.BASE_DIV(BASE_DIV)) i_div (
        .clk    (clk),
        .rst    (rst),
        .sel    (osc_sel_e'(freq_sel)),
        .freeze (pwr_down),
        .car    (car),
        .ratio  (ratio)
    );

    cwm_gate #(.N_W(N_W), .RAT_W(RAT_W)) i_gate (
        .clk      (clk),
        .rst      (rst),
        .wr_enter (wr_enter),
        .din      (din),
        .sclk     (sclk),
        .pulse_n  (pulse_n),
        .ratio    (ratio),
        .gate_off (gate_off)
    );

    assign drv_on = ~tx_dis & ~pwr_down & ~gate_off;
    assign tick_c = car.wrap & ~pwr_down;

    cwm_bridge i_bridge (
        .clk     (clk),
        .rst     (rst),
        .car     (car),
        .tick_in (tick_c),
        .drv_on  (drv_on),
        .tx1     (tx1),
        .tx2     (tx2),
        .tick    (carrier_tick),
        .slot    (slot_idx)
    );

endmodule

// File: rtl/cwm_checker.sv
module cwm_checker (
    input logic       clk,
    input logic       rst,
    input logic       tx_dis,
    input logic       pwr_down,
    input logic       sclk,
    input logic       tx1,
    input logic       tx2,
    input logic       carrier_tick,
    input logic [5:0] slot_idx
);

    logic sclk_prev;
    always_ff @(posedge clk) begin
        if (rst) sclk_prev <= 1'b0;
        else     sclk_prev <= sclk;
    end

    p_antiphase_r2: assert property (@(posedge clk) disable iff (rst)
        !(tx1 && tx2));

    p_tick_single_r1: assert property (@(posedge clk) disable iff (rst)
        carrier_tick |=> !carrier_tick);

    p_slot_restart_r9: assert property (@(posedge clk) disable iff (rst)
        carrier_tick |=> (slot_idx == 6'd0));

    p_disable_low_r7: assert property (@(posedge clk) disable iff (rst)
        tx_dis |=> (!tx1 && !tx2));

    p_powerdown_r8: assert property (@(posedge clk) disable iff (rst)
        pwr_down |=> (!tx1 && !tx2 && !carrier_tick));

    p_exit_drives_r6: assert property (@(posedge clk) disable iff (rst)
        (sclk && !sclk_prev && !tx_dis && !pwr_down) |=> (tx1 || tx2));

endmodule

bind carrier_write_mod cwm_checker i_chk (
    .clk          (clk),
    .rst          (rst),
    .tx_dis       (tx_dis),
    .pwr_down     (pwr_down),
    .sclk         (sclk),
    .tx1          (tx1),
    .tx2          (tx2),
    .carrier_tick (carrier_tick),
    .slot_idx     (slot_idx)
);

// File: tb/test_carrier_write_mod.sv
`timescale 1ns/1ps
module test_carrier_write_mod;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] freq_sel = 2'd0;
    logic       tx_dis = 1'b0;
    logic       pwr_down = 1'b0;
    logic       wr_enter = 1'b0;
    logic [3:0] pulse_n = 4'd0;
    logic       din = 1'b0;
    logic       sclk = 1'b0;
    logic       tx1, tx2, carrier_tick;
    logic [5:0] slot_idx;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    carrier_write_mod i_carrier_write_mod (
        .clk(clk), .rst(rst), .freq_sel(freq_sel), .tx_dis(tx_dis),
        .pwr_down(pwr_down), .wr_enter(wr_enter), .pulse_n(pulse_n),
        .din(din), .sclk(sclk), .tx1(tx1), .tx2(tx2),
        .carrier_tick(carrier_tick), .slot_idx(slot_idx)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int ratio_of(logic [1:0] s);
        case (s)
            2'd0: return 32;
            2'd1: return 96;
            2'd2: return 64;
            default: return 128;
        endcase
    endfunction

    task automatic wait_tick();
        for (int i = 0; i < 400; i++) begin
            step();
            if (carrier_tick) return;
        end
    endtask

    // Counts cycles in which not exactly one leg is high
    task automatic one_high_run(int cycles, output int bad);
        bad = 0;
        for (int i = 0; i < cycles; i++) begin
            step();
            if ((tx1 ^ tx2) != 1'b1) bad++;
        end
    endtask

    task automatic exit_write();
        sclk = 1'b1;
        step();
        sclk = 1'b0;
        din = 1'b0;
        step();
    endtask

    task automatic t_reset();
        int bad = 0;
        rst = 1'b1;
        for (int i = 0; i < 4; i++) begin
            step();
            if (tx1 || tx2 || carrier_tick || slot_idx != 0) bad++;
        end
        chk("R12 outputs zero in reset", bad, 0);
        rst = 1'b0;
    endtask

    task automatic t_period(logic [1:0] sel);
        int r = ratio_of(sel);
        int bad_slot = 0, bad_tx = 0, bad_tick = 0;
        freq_sel = sel;
        wait_tick();
        wait_tick();
        for (int c = 0; c < r; c++) begin
            step();
            if (int'(slot_idx) != (c * 64) / r) bad_slot++;
            if (tx1 != (c < r / 2) || tx2 != !(c < r / 2)) bad_tx++;
            if (carrier_tick != (c == r - 1)) bad_tick++;
        end
        chk($sformatf("R1 tick placement sel=%0d", sel), bad_tick, 0);
        chk($sformatf("R2 half-period legs sel=%0d", sel), bad_tx, 0);
        chk($sformatf("R9 slot sweep sel=%0d", sel), bad_slot, 0);
    endtask

    task automatic t_ignore_din();
        int bad = 0;
        freq_sel = 2'd0;
        for (int c = 0; c < 64; c++) begin
            din = c[0] ^ c[2];
            step();
            if ((tx1 ^ tx2) != 1'b1) bad++;
        end
        din = 1'b0;
        chk("R10 din ignored outside write mode", bad, 0);
    endtask

    task automatic t_transparent();
        int off = 0, bad = 0;
        pulse_n = 4'd0;
        din = 1'b1;
        wr_enter = 1'b1;
        step();
        wr_enter = 1'b0;
        if (!tx1 && !tx2) off++;
        for (int i = 0; i < 39; i++) begin
            step();
            if (!tx1 && !tx2) off++;
        end
        chk("R3 din high holds legs low", off, 40);
        din = 1'b0;
        one_high_run(40, bad);
        chk("R3 din low passes carrier", bad, 0);
        din = 1'b1;
        step();
        chk("R3 din high again turns off", int'(tx1 | tx2), 0);
        sclk = 1'b1;
        step();
        chk("R6 sclk rise restores carrier", int'(tx1 ^ tx2), 1);
        sclk = 1'b0;
        one_high_run(40, bad);
        chk("R6 stays out of write mode with din high", bad, 0);
        din = 1'b0;
        step();
    endtask

    task automatic t_gap(logic [1:0] sel, int n, bit second_rise);
        int r = ratio_of(sel);
        int off = 0, ticks = 0, bad = 0;
        freq_sel = sel;
        wait_tick();
        din = 1'b0;
        pulse_n = 4'(n);
        wr_enter = 1'b1;
        step();
        wr_enter = 1'b0;
        chk("R4 carrier on before gap", int'(tx1 ^ tx2), 1);
        din = 1'b1;
        for (int i = 0; i < 4000; i++) begin
            step();
            if (!tx1 && !tx2) begin
                off++;
                if (carrier_tick) ticks++;
                if (second_rise && off == 40) din = 1'b0;
                if (second_rise && off == 41) din = 1'b1;
            end else begin
                break;
            end
        end
        if (second_rise)
            chk($sformatf("R5 gap with extra rise n=%0d", n), off, n * r);
        else
            chk($sformatf("R4 gap length n=%0d", n), off, n * r);
        chk($sformatf("R11 ticks during gap n=%0d", n), ticks, n);
        one_high_run(50, bad);
        chk("R4 carrier back after gap with din high", bad, 0);
        exit_write();
    endtask

    task automatic t_abort();
        int off = 0, bad = 0;
        freq_sel = 2'd0;
        din = 1'b0;
        pulse_n = 4'd15;
        wr_enter = 1'b1;
        step();
        wr_enter = 1'b0;
        din = 1'b1;
        for (int i = 0; i < 20; i++) begin
            step();
            if (!tx1 && !tx2) off++;
        end
        chk("R4 gap running before abort", off, 20);
        sclk = 1'b1;
        step();
        chk("R6 sclk rise cancels gap", int'(tx1 ^ tx2), 1);
        sclk = 1'b0;
        one_high_run(30, bad);
        chk("R6 carrier stays on after abort", bad, 0);
        din = 1'b0;
        step();
    endtask

    task automatic t_disable();
        int bad = 0, ticks = 0;
        freq_sel = 2'd0;
        tx_dis = 1'b1;
        step();
        for (int i = 0; i < 100; i++) begin
            step();
            if (tx1 || tx2) bad++;
            if (carrier_tick) ticks++;
        end
        chk("R7 legs low while disabled", bad, 0);
        chk("R7 divider runs while disabled", int'(ticks >= 3), 1);
        tx_dis = 1'b0;
        step();
        chk("R7 carrier back after enable", int'(tx1 ^ tx2), 1);
    endtask

    task automatic t_pd();
        int bad = 0;
        logic [5:0] held;
        pwr_down = 1'b1;
        step();
        held = slot_idx;
        for (int i = 0; i < 150; i++) begin
            step();
            if (tx1 || tx2 || carrier_tick || slot_idx != held) bad++;
        end
        chk("R8 power-down freezes and silences", bad, 0);
        pwr_down = 1'b0;
        step();
        chk("R8 carrier back after power-up", int'(tx1 ^ tx2), 1);
    endtask

    initial begin
        t_reset();
        t_period(2'd0);
        t_period(2'd1);
        t_period(2'd2);
        t_period(2'd3);
        t_ignore_din();
        t_transparent();
        t_gap(2'd0, 3, 1'b0);
        t_gap(2'd0, 2, 1'b1);
        t_gap(2'd1, 2, 1'b0);
        t_abort();
        t_disable();
        t_pd();
        t_period(2'd0);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule